// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit-data, 16-bit-address CPU bus and a cartridge that holds a ROM far larger than the CPU can see and a small external RAM. The CPU programs four control registers by writing into its own ROM address range. These registers are a RAM enable, a five-bit ROM bank, a two-bit secondary bank and a mode flag. A read from the ROM range is turned into a physical ROM address. An access to the RAM window goes to an internal RAM that is sized by a parameter.

There are two ROM windows. The upper window (0x4000–0x7FFF) shows the bank formed from both bank registers. The lower window (0x0000–0x3FFF) normally shows the start of the ROM. When the mode flag is set, the secondary register also banks the lower window and selects the RAM bank. Every result is registered and appears one clock after the request.

Top module: `bank_ctl`

## Requirements
- R1: After reset the ROM bank register holds 1, the secondary bank and the mode flag are 0, and RAM is disabled. `rom_req` and `rd_valid` are low.
- R2: A write to 0x0000–0x1FFF enables RAM when data bits [3:0] equal 0xA. Any other value disables RAM.
- R3: A write to 0x2000–0x3FFF loads the ROM bank from data bits [4:0]. A value of 0 is stored as 1, so the register is never 0.
- R4: A write to 0x4000–0x5FFF loads the secondary bank from data bits [1:0].
- R5: A write to 0x6000–0x7FFF sets the mode flag from data bit 0.
- R6: A read in 0x0000–0x3FFF maps to the address unchanged when mode is 0. When mode is 1 it maps to 0x4000 × zero-bank + address, where zero-bank = secondary × 32.
- R7: A read in 0x4000–0x7FFF maps to 0x4000 × high-bank + (address − 0x4000), where high-bank = (secondary × 32) OR ROM bank.
- R8: The zero-bank and the high-bank are both reduced modulo ROM_BANKS, a power of two.
- R9: While RAM is disabled, reads in 0xA000–0xBFFF return 0xFF and writes there leave the RAM unchanged.
- R10: The RAM index is bank × 2^RAM_OFS_BITS + address[RAM_OFS_BITS-1:0]. The bank is the secondary register in mode 1 and 0 in mode 0.
- R11: A read in 0x0000–0x7FFF gives `rom_req` high for one cycle, on the next clock. A read in 0xA000–0xBFFF gives `rd_valid` high for one cycle, on the next clock. No read gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read request this cycle |
| cpu_wr | input | 1 | Write request this cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | RAM-window read data, valid with `rd_valid` |
| rd_valid | output | 1 | RAM-window read result is present |
| rom_req | output | 1 | `rom_addr` holds a new ROM fetch address |
| rom_addr | output | $clog2(ROM_BANKS)+14 | Physical ROM address |

## Verification
The assertions assume that the CPU never raises read and write in the same cycle. They also assume that no access falls outside the ROM range and the RAM window. The bench issues one operation per step and only uses addresses below 0x8000 or in 0xA000–0xBFFF, so it stays within these limits. The bench sets ROM_BANKS to 64 so that the top secondary bit is dropped by the modulo and the bank reduction of R8 can be seen.

// File: rtl/bank_ctl_pkg.sv
`timescale 1ns/1ps
package bank_ctl_pkg;
  // 8 KiB windows of the CPU map, selected by address bits [15:13]
  typedef enum logic [2:0] {
    WIN_ENABLE  = 3'd0,
    WIN_ROMBANK = 3'd1,
    WIN_SECOND  = 3'd2,
    WIN_MODE    = 3'd3,
    WIN_VIDEO0  = 3'd4,
    WIN_RAM     = 3'd5,
    WIN_HIGH0   = 3'd6,
    WIN_HIGH1   = 3'd7
  } win_e;

  function automatic win_e win_of(input logic [15:0] a);
    return win_e'(a[15:13]);
  endfunction
endpackage

// File: rtl/bank_ctl_regs.sv
`timescale 1ns/1ps
module bank_ctl_regs
  import bank_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  win_e       win,
  input  logic [7:0] wdata,
  output logic       ram_en,
  output logic [4:0] rom_bank,
  output logic [1:0] sec_bank,
  output logic       mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en   <= 1'b0;
      rom_bank <= 5'd1;
      sec_bank <= 2'd0;
      mode     <= 1'b0;
    end else if (wr_en) begin
      case (win)
        WIN_ENABLE:  ram_en   <= (wdata[3:0] == 4'hA);
        WIN_ROMBANK: rom_bank <= (wdata[4:0] == 5'd0) ? 5'd1 : wdata[4:0];
        WIN_SECOND:  sec_bank <= wdata[1:0];
        WIN_MODE:    mode     <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bank_ctl_map.sv
`timescale 1ns/1ps
module bank_ctl_map #(
  parameter int ROM_BW       = 7,
  parameter int RAM_OFS_BITS = 8
) (
  input  logic [15:0]               addr,
  input  logic [4:0]                rom_bank,
  input  logic [1:0]                sec_bank,
  input  logic                      mode,
  output logic [ROM_BW+13:0]        rom_phys,
  output logic [RAM_OFS_BITS+1:0]   ram_idx
);
  logic [6:0]        zero_full, high_full;
  logic [ROM_BW-1:0] zero_m, high_m, low_bank;

  always_comb begin
    zero_full = {sec_bank, 5'd0};
    high_full = zero_full | {2'd0, rom_bank};
    zero_m    = zero_full[ROM_BW-1:0];
    high_m    = high_full[ROM_BW-1:0];
    low_bank  = mode ? zero_m : '0;
    rom_phys  = addr[14] ? {high_m, addr[13:0]} : {low_bank, addr[13:0]};
    ram_idx   = {(mode ? sec_bank : 2'd0), addr[RAM_OFS_BITS-1:0]};
  end
endmodule

// File: rtl/bank_ctl_ram.sv
`timescale 1ns/1ps
module bank_ctl_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/bank_ctl.sv
`timescale 1ns/1ps
module bank_ctl
  import bank_ctl_pkg::*;
#(
  parameter int ROM_BANKS    = 128,
  parameter int RAM_OFS_BITS = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [15:0]                     cpu_addr,
  input  logic                            cpu_rd,
  input  logic                            cpu_wr,
  input  logic [7:0]                      cpu_wdata,
  output logic [7:0]                      cpu_rdata,
  output logic                            rd_valid,
  output logic                            rom_req,
  output logic [$clog2(ROM_BANKS)+13:0]   rom_addr
);
  localparam int ROM_BW = $clog2(ROM_BANKS);
  localparam int ROM_AW = ROM_BW + 14;
  localparam int RAM_IW = RAM_OFS_BITS + 2;

  win_e              win;
  logic              in_rom, in_ram;
  logic              ram_en, mode, en_q;
  logic [4:0]        rom_bank;
  logic [1:0]        sec_bank;
  logic [ROM_AW-1:0] rom_phys;
  logic [RAM_IW-1:0] ram_idx;
  logic [7:0]        ram_q;

  assign win    = win_of(cpu_addr);
  assign in_rom = ~cpu_addr[15];
  assign in_ram = (win == WIN_RAM);

  bank_ctl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .win(win), .wdata(cpu_wdata),
    .ram_en(ram_en), .rom_bank(rom_bank), .sec_bank(sec_bank), .mode(mode)
  );

  bank_ctl_map #(.ROM_BW(ROM_BW), .RAM_OFS_BITS(RAM_OFS_BITS)) u_map (
    .addr(cpu_addr), .rom_bank(rom_bank), .sec_bank(sec_bank), .mode(mode),
    .rom_phys(rom_phys), .ram_idx(ram_idx)
  );

  bank_ctl_ram #(.AW(RAM_IW), .DW(8)) u_ram (
    .clk(clk), .we(cpu_wr & in_ram & ram_en), .re(cpu_rd & in_ram),
    .addr(ram_idx), .wdata(cpu_wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_req  <= 1'b0;
      rd_valid <= 1'b0;
      en_q     <= 1'b0;
      rom_addr <= '0;
    end else begin
      rom_req  <= cpu_rd & in_rom;
      rd_valid <= cpu_rd & in_ram;
      en_q     <= ram_en;
      if (cpu_rd & in_rom) rom_addr <= rom_phys;
    end
  end

  assign cpu_rdata = en_q ? ram_q : 8'hFF;
endmodule

// File: rtl/bank_ctl_chk.sv
`timescale 1ns/1ps
module bank_ctl_chk #(
  parameter int ROM_AW = 21
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        cpu_rdata,
  input logic              rd_valid,
  input logic              rom_req,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ram_en,
  input logic [4:0]        rom_bank,
  input logic              mode
);
  p_rom_req_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_addr[15]) |=> (rom_req && !rd_valid));

  p_ram_valid_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:13] == 3'b101) |=> (rd_valid && !rom_req));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> (!rom_req && !rd_valid));

  p_bank_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    rom_bank != 5'd0);

  p_disabled_ff_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:13] == 3'b101 && !ram_en) |=> (cpu_rdata == 8'hFF));

  p_lowmap_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:14] == 2'b00 && !mode) |=>
      (rom_addr[13:0] == $past(cpu_addr[13:0]) && rom_addr[ROM_AW-1:14] == '0));

  p_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:13] == 3'b000) |=> (ram_en == ($past(cpu_wdata[3:0]) == 4'hA)));
endmodule

bind bank_ctl bank_ctl_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rd_valid(rd_valid),
  .rom_req(rom_req), .rom_addr(rom_addr), .ram_en(ram_en),
  .rom_bank(rom_bank), .mode(mode)
);

// File: tb/tb_bank_ctl.sv
`timescale 1ns/1ps
module tb_bank_ctl;
  localparam int NB  = 64;
  localparam int OFS = 8;
  localparam int AW  = $clog2(NB) + 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   cpu_addr = '0;
  logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          rd_valid, rom_req;
  logic [AW-1:0] rom_addr;

  bank_ctl #(.ROM_BANKS(NB), .RAM_OFS_BITS(OFS)) dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rd_valid(rd_valid),
    .rom_req(rom_req), .rom_addr(rom_addr)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  bit  m_en = 0, m_mode = 0;
  int  m_rb = 1, m_sec = 0;
  int  m_ram [0:(4<<OFS)-1];
  bit  e_req, e_valid;
  longint e_addr = 0;
  int  e_rdata;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input int a, input int d, input string req);
    int idx, zb, hb;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a[15:0]; cpu_wdata = d[7:0];
    e_req   = rd && a < 'h8000;
    e_valid = rd && a >= 'hA000 && a < 'hC000;
    zb = (m_sec * 32) % NB;
    hb = ((m_sec * 32) | m_rb) % NB;
    if (e_req) begin
      if (a < 'h4000) e_addr = m_mode ? longint'(zb) * 'h4000 + a : a;
      else            e_addr = longint'(hb) * 'h4000 + (a - 'h4000);
    end
    idx = (m_mode ? m_sec : 0) * (1 << OFS) + (a % (1 << OFS));
    if (e_valid) e_rdata = m_en ? m_ram[idx] : 'hFF;
    if (wr) begin
      if (a < 'h2000)       m_en = ((d % 16) == 'hA);
      else if (a < 'h4000)  m_rb = ((d % 32) == 0) ? 1 : (d % 32);
      else if (a < 'h6000)  m_sec = d % 4;
      else if (a < 'h8000)  m_mode = d % 2;
      else if (a >= 'hA000 && a < 'hC000 && m_en) m_ram[idx] = d % 256;
    end
    @(posedge clk); #1;
    cpu_rd = 0; cpu_wr = 0;
    chk(req, "rom_req", rom_req, e_req);
    chk(req, "rd_valid", rd_valid, e_valid);
    chk(req, "rom_addr", rom_addr, e_addr);
    if (e_valid) chk(req, "rdata", cpu_rdata, e_rdata);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rom_req in reset", rom_req, 0);
    chk("R1", "rd_valid in reset", rd_valid, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1", "rom_req after reset", rom_req, 0);
    step(1, 0, 'h4123, 0, "R1");      // bank 1 after reset (R7 path)
    step(1, 0, 'hA000, 0, "R1");      // RAM disabled after reset
    step(1, 0, 'h0150, 0, "R6");
    step(0, 0, 'h0000, 0, "R11");     // idle cycle
    step(0, 1, 'h2000, 'h00, "R3");
    step(1, 0, 'h4000, 0, "R3");      // zero promoted to one
    step(0, 1, 'h2100, 'hE5, "R3");
    step(1, 0, 'h7FFF, 0, "R7");
    step(0, 1, 'h4000, 'hFD, "R4");
    step(1, 0, 'h4001, 0, "R4");
    step(1, 0, 'h2222, 0, "R6");
    step(0, 1, 'h6000, 'hFF, "R5");
    step(1, 0, 'h2222, 0, "R5");
    step(0, 1, 'h5FFF, 'h02, "R8");
    step(1, 0, 'h1000, 0, "R8");
    step(1, 0, 'h4010, 0, "R8");
    step(0, 1, 'h1F00, 'h1A, "R2");
    step(0, 1, 'hA005, 'h77, "R10");  // mode 1, bank 2
    step(0, 1, 'h6000, 'h00, "R10");
    step(0, 1, 'hA005, 'h33, "R10");  // mode 0, bank 0
    step(1, 0, 'hA005, 0, "R10");
    step(0, 1, 'h7000, 'h01, "R10");
    step(1, 0, 'hB105, 0, "R10");     // offset alias into bank 2
    step(0, 1, 'h0000, 'h0B, "R2");
    step(0, 1, 'hA005, 'h99, "R9");   // ignored
    step(1, 0, 'hA005, 0, "R9");
    step(0, 1, 'h0000, 'h0A, "R2");
    step(1, 0, 'hA005, 0, "R9");      // still 0x77
    step(0, 1, 'h0000, 'hA0, "R2");
    step(1, 0, 'hA005, 0, "R2");
    step(0, 1, 'h0000, 'hFA, "R2");
    step(1, 0, 'hA005, 0, "R2");
    step(1, 0, 'h3FFF, 0, "R6");
    step(0, 0, 'h4000, 0, "R11");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule